// File: doc/BRIEF.md
# PCI Configuration Access Port Bridge

This block sits on a host I/O-port bus and gives software an indirect way into PCI configuration space. Two 32-bit port windows are decoded. A write to the address window at I/O 0xCF8 latches a target word holding an enable flag, a bus number, a device number, a function number and a dword index. A later access to the data window at I/O 0xCFC is turned into one single-cycle read or write on a downstream configuration bus aimed at that target. The byte enables of the host access pass straight through to that bus.

The address word has this bit layout: the enable flag is bit 31, bits 30:24 are reserved, the bus number is bits 23:16, the device number is bits 15:11, the function number is bits 10:8, the dword index is bits 7:2, and bits 1:0 are always zero. Data-port accesses reach the configuration bus only while the latched enable flag is 1. Software therefore writes the target word with bit 31 set, and then it reads or writes the data port.

A single local function, placed at a parameterised bus, device and function number, answers the configuration bus. It models a 64-dword space. Dwords 0 to 15 hold a fixed-format header, and dwords 16 to 63 are a body that reads as zero. A target with no function behind it reads as all ones.

Top module: `cfgport_bridge`

## Requirements
- R1: While reset is asserted, io_rvalid and cfg_req stay 0. After reset, the address window reads 0, so the enable flag starts cleared.
- R2: A write to ports 0xCF8 to 0xCFB updates only the bytes whose io_be bit is set. A read of that window returns the last value written, with bits 30:24 and bits 1:0 reading 0.
- R3: A data-window access (ports 0xCFC to 0xCFF) made while the enable flag is set raises cfg_req in the same cycle, for exactly that cycle. In that cycle cfg_bus comes from address bits 23:16, cfg_dev from 15:11, cfg_fn from 10:8 and cfg_dw from 7:2, and cfg_we follows io_we.
- R4: A data-window access made while the enable flag is clear raises no cfg_req. A read returns 0xFFFFFFFF, and a write changes no configuration state.
- R5: cfg_be equals io_be, with bit i selecting byte i (bits 8i+7:8i). A byte write at port 0xCFD with io_be = 0010 changes only byte 1 of the target dword.
- R6: io_rvalid is 1 in the cycle after each read request, and only then. io_rdata holds the read value in that cycle, and back-to-back requests are accepted every cycle.
- R7: A configuration read whose bus, device or function does not match the local function returns 0xFFFFFFFF.
- R8: Dword 0 reads {DEVICE_ID, VENDOR_ID}, with the vendor number in bits 15:0. Dword 2 reads {CLASS_CODE, REV_ID}, with the revision in bits 7:0 and class 0x02 / subclass 0x00 (Ethernet) in bits 31:16 by default.
- R9: In dword 3, byte 0 (cache line size) and byte 1 (latency timer) are writable. Byte 2 (header type) and byte 3 read 0.
- R10: In dword 4 (base address 0), bits below BAR0_SIZE_LOG2 read 0 and the upper bits are writable. Dwords 5 to 9 (base addresses 1 to 5) read 0.
- R11: In dword 1, only the bits set in CMD_WMASK are writable and bits 31:16 read 0. In dword 15, byte 0 is writable and byte 1 reads 0x01. Dwords 16 to 63 read 0 and ignore writes.
- R12: An access to a port outside 0xCF8 to 0xCFF changes no state, and a read of such a port returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Host I/O access valid this cycle |
| io_we | input | 1 | 1 = port write, 0 = port read |
| io_port | input | 16 | Host I/O byte address |
| io_be | input | 4 | Byte lanes of the dword window |
| io_wdata | input | 32 | Lane-aligned write data |
| io_rvalid | output | 1 | Read response valid |
| io_rdata | output | 32 | Read response data |
| cfg_req | output | 1 | Configuration bus access strobe |
| cfg_we | output | 1 | Configuration write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_dw | output | 6 | Target dword index |
| cfg_be | output | 4 | Configuration byte enables |
| cfg_wdata | output | 32 | Configuration write data |

## Verification
The bench builds the block with its defaults: vendor 0x8086, device 0x109A, revision 0x03, class 0x020000, the local function at bus 0 / device 3 / function 0, a 128 KB base address 0 (BAR0_SIZE_LOG2 = 17) and a command write mask of 0x0007. With the function at device 3, nearby targets that differ only in device, function or bus can be used to show the all-ones miss. The 17-bit BAR0 size makes the read-only low bits of base address 0 clearly visible after an all-ones write. The narrow command mask shows which command bits are writable and which are read-only.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam logic [15:0] ADDR_PORT = 16'h0CF8;
    localparam logic [15:0] DATA_PORT = 16'h0CFC;
    localparam logic [31:0] ADDR_KEEP = 32'h80FF_FFFC;
    localparam logic [31:0] ALL_ONES  = 32'hFFFF_FFFF;
    localparam int unsigned LANES     = 4;

    typedef struct packed {
        logic       en;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] dw;
    } cfg_target_t;

    function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  be);
        logic [31:0] r;
        r = old_v;
        for (int i = 0; i < LANES; i++) begin
            if (be[i]) r[8*i +: 8] = new_v[8*i +: 8];
        end
        return r;
    endfunction

    function automatic cfg_target_t split_addr(input logic [31:0] a);
        cfg_target_t t;
        t.en  = a[31];
        t.bus = a[23:16];
        t.dev = a[15:11];
        t.fn  = a[10:8];
        t.dw  = a[7:2];
        return t;
    endfunction

endpackage

// File: rtl/cfgport_addr_reg.sv
module cfgport_addr_reg
    import cfgport_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] addr_q
);

    typedef struct packed {
        logic [31:0] addr;
    } areg_t;

    areg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.addr = lane_merge(st_q.addr, wdata, be) & ADDR_KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_q = st_q.addr;

    AST_ADDR_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q[30:24] == 7'd0) && (addr_q[1:0] == 2'd0)); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(addr_q)); // R2
    AST_ADDR_EN_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && be[3]) |=> (addr_q[31] == $past(wdata[31]))); // R2

endmodule

// File: rtl/cfgport_local_fn.sv
module cfgport_local_fn
    import cfgport_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID      = 16'h8086,
    parameter logic [15:0] DEVICE_ID      = 16'h109A,
    parameter logic [7:0]  REV_ID         = 8'h03,
    parameter logic [23:0] CLASS_CODE     = 24'h020000,
    parameter int unsigned BAR0_SIZE_LOG2 = 17,
    parameter logic [15:0] CMD_WMASK      = 16'h0007
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [5:0]  dw,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);

    localparam logic [31:0] BAR_MASK  = ~((32'd1 << BAR0_SIZE_LOG2) - 32'd1);
    localparam logic [5:0]  DW_ID     = 6'd0;
    localparam logic [5:0]  DW_CMD    = 6'd1;
    localparam logic [5:0]  DW_CLASS  = 6'd2;
    localparam logic [5:0]  DW_MISC   = 6'd3;
    localparam logic [5:0]  DW_BAR0   = 6'd4;
    localparam logic [5:0]  DW_IRQ    = 6'd15;
    localparam logic [7:0]  IRQ_PIN   = 8'h01;

    typedef struct packed {
        logic [15:0] cmd;
        logic [7:0]  cls;
        logic [7:0]  lat;
        logic [31:0] bar;
        logic [7:0]  intl;
    } fn_state_t;

    fn_state_t   st_d, st_q;
    logic [31:0] merged;

    always_comb begin
        unique case (dw)
            DW_ID:    rdata = {DEVICE_ID, VENDOR_ID};
            DW_CMD:   rdata = {16'h0000, st_q.cmd};
            DW_CLASS: rdata = {CLASS_CODE, REV_ID};
            DW_MISC:  rdata = {16'h0000, st_q.lat, st_q.cls};
            DW_BAR0:  rdata = st_q.bar;
            DW_IRQ:   rdata = {16'h0000, IRQ_PIN, st_q.intl};
            default:  rdata = 32'h0000_0000;
        endcase
    end

    always_comb begin
        merged = lane_merge(rdata, wdata, be);
        st_d   = st_q;
        if (wr_en) begin
            unique case (dw)
                DW_CMD:  st_d.cmd = merged[15:0] & CMD_WMASK;
                DW_MISC: begin
                    st_d.cls = merged[7:0];
                    st_d.lat = merged[15:8];
                end
                DW_BAR0: st_d.bar  = merged & BAR_MASK;
                DW_IRQ:  st_d.intl = merged[7:0];
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_BAR_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.bar & ~BAR_MASK) == 32'd0); // R10
    AST_BODY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (dw >= 6'd16)) |=> $stable(st_q)); // R11
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q)); // R4

endmodule

// File: rtl/cfgport_bridge.sv
module cfgport_bridge
    import cfgport_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID      = 16'h8086,
    parameter logic [15:0] DEVICE_ID      = 16'h109A,
    parameter logic [7:0]  REV_ID         = 8'h03,
    parameter logic [23:0] CLASS_CODE     = 24'h020000,
    parameter logic [7:0]  FN_BUS         = 8'd0,
    parameter logic [4:0]  FN_DEV         = 5'd3,
    parameter logic [2:0]  FN_NUM         = 3'd0,
    parameter int unsigned BAR0_SIZE_LOG2 = 17,
    parameter logic [15:0] CMD_WMASK      = 16'h0007
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_req,
    input  logic        io_we,
    input  logic [15:0] io_port,
    input  logic [3:0]  io_be,
    input  logic [31:0] io_wdata,
    output logic        io_rvalid,
    output logic [31:0] io_rdata,
    output logic        cfg_req,
    output logic        cfg_we,
    output logic [7:0]  cfg_bus,
    output logic [4:0]  cfg_dev,
    output logic [2:0]  cfg_fn,
    output logic [5:0]  cfg_dw,
    output logic [3:0]  cfg_be,
    output logic [31:0] cfg_wdata
);

    localparam logic [13:0] ADDR_WIN = ADDR_PORT[15:2];
    localparam logic [13:0] DATA_WIN = DATA_PORT[15:2];

    typedef struct packed {
        logic        rvalid;
        logic [31:0] rdata;
    } rsp_t;

    logic        addr_sel, data_sel, fn_hit;
    logic [31:0] addr_q, fn_rdata;
    cfg_target_t tgt;
    rsp_t        rsp_d, rsp_q;

    assign addr_sel = io_req && (io_port[15:2] == ADDR_WIN);
    assign data_sel = io_req && (io_port[15:2] == DATA_WIN);

    cfgport_addr_reg u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (addr_sel && io_we),
        .be     (io_be),
        .wdata  (io_wdata),
        .addr_q (addr_q)
    );

    assign tgt       = split_addr(addr_q);
    assign cfg_req   = data_sel && tgt.en;
    assign cfg_we    = io_we;
    assign cfg_bus   = tgt.bus;
    assign cfg_dev   = tgt.dev;
    assign cfg_fn    = tgt.fn;
    assign cfg_dw    = tgt.dw;
    assign cfg_be    = io_be;
    assign cfg_wdata = io_wdata;

    assign fn_hit = (tgt.bus == FN_BUS) && (tgt.dev == FN_DEV) && (tgt.fn == FN_NUM);

    cfgport_local_fn #(
        .VENDOR_ID      (VENDOR_ID),
        .DEVICE_ID      (DEVICE_ID),
        .REV_ID         (REV_ID),
        .CLASS_CODE     (CLASS_CODE),
        .BAR0_SIZE_LOG2 (BAR0_SIZE_LOG2),
        .CMD_WMASK      (CMD_WMASK)
    ) u_fn (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_req && cfg_we && fn_hit),
        .dw    (cfg_dw),
        .be    (cfg_be),
        .wdata (cfg_wdata),
        .rdata (fn_rdata)
    );

    always_comb begin
        rsp_d.rvalid = io_req && !io_we;
        rsp_d.rdata  = ALL_ONES;
        if (addr_sel)               rsp_d.rdata = addr_q;
        else if (cfg_req && fn_hit) rsp_d.rdata = fn_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign io_rvalid = rsp_q.rvalid;
    assign io_rdata  = rsp_q.rdata;

    AST_RVALID_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        io_rvalid |-> $past(io_req && !io_we)); // R6
    AST_DISABLED_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (data_sel && !io_we && !addr_q[31]) |=> (io_rdata == ALL_ONES)); // R4
    AST_ABSENT_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_we && !fn_hit) |=> (io_rdata == ALL_ONES)); // R7
    AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !addr_sel && !data_sel) |=> $stable(addr_q)); // R12
    AST_LANE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        io_req |-> io_be[io_port[1:0]]); // R5

endmodule

// File: tb/tb_cfgport_bridge.sv
module tb_cfgport_bridge;

    localparam logic [15:0] VID    = 16'h8086;
    localparam logic [15:0] DID    = 16'h109A;
    localparam logic [7:0]  REV    = 8'h03;
    localparam logic [23:0] CLS    = 24'h020000;
    localparam logic [7:0]  FBUS   = 8'd0;
    localparam logic [4:0]  FDEV   = 5'd3;
    localparam logic [2:0]  FFN    = 3'd0;
    localparam int          BARLOG = 17;
    localparam logic [15:0] CMDM   = 16'h0007;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        io_req, io_we;
    logic [15:0] io_port;
    logic [3:0]  io_be;
    logic [31:0] io_wdata;
    logic        io_rvalid;
    logic [31:0] io_rdata;
    logic        cfg_req, cfg_we;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_fn;
    logic [5:0]  cfg_dw;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;

    cfgport_bridge dut (
        .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_we(io_we), .io_port(io_port),
        .io_be(io_be), .io_wdata(io_wdata), .io_rvalid(io_rvalid), .io_rdata(io_rdata),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
        .cfg_fn(cfg_fn), .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata)
    );

    int vectors = 0;
    int miscompares = 0;
    logic checking = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference state
    logic [31:0] m_addr;
    logic [15:0] m_cmd;
    logic [7:0]  m_cls, m_lat, m_intl;
    logic [31:0] m_bar;
    logic        exp_rvalid;
    logic [31:0] exp_rdata;
    string       exp_tag = "R1";
    string       cur_tag = "R1";

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n, input logic [3:0] b);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = b[i] ? n[8*i +: 8] : o[8*i +: 8];
        return r;
    endfunction

    function automatic logic [31:0] m_read(input int dw);
        case (dw)
            0:       return {DID, VID};
            1:       return {16'h0, m_cmd};
            2:       return {CLS, REV};
            3:       return {16'h0, m_lat, m_cls};
            4:       return m_bar;
            15:      return {16'h0, 8'h01, m_intl};
            default: return 32'h0;
        endcase
    endfunction

    task m_write(input int dw, input logic [31:0] v);
        case (dw)
            1:  m_cmd = v[15:0] & CMDM;
            3:  begin m_cls = v[7:0]; m_lat = v[15:8]; end
            4:  m_bar = v & ~((32'd1 << BARLOG) - 32'd1);
            15: m_intl = v[7:0];
            default: ;
        endcase
    endtask

    function automatic logic m_hit();
        return (m_addr[23:16] == FBUS) && (m_addr[15:11] == FDEV) && (m_addr[10:8] == FFN);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 0; m_cmd = 0; m_cls = 0; m_lat = 0; m_intl = 0; m_bar = 0;
            exp_rvalid = 0; exp_rdata = 0;
        end else begin
            exp_rvalid = io_req && !io_we;
            exp_tag    = cur_tag;
            exp_rdata  = 32'hFFFF_FFFF;
            if (io_req) begin
                if (io_port >= 16'h0CF8 && io_port <= 16'h0CFB) begin
                    if (!io_we) exp_rdata = m_addr;
                    else m_addr = mrg(m_addr, io_wdata, io_be) & 32'h80FF_FFFC;
                end else if (io_port >= 16'h0CFC && io_port <= 16'h0CFF && m_addr[31] && m_hit()) begin
                    if (!io_we) exp_rdata = m_read(int'(m_addr[7:2]));
                    else m_write(int'(m_addr[7:2]), mrg(m_read(int'(m_addr[7:2])), io_wdata, io_be));
                end
            end
        end
    end

    // Per-cycle comparison, half a period after the edge
    always @(negedge clk) begin
        if (rst_n && checking) begin
            logic e_req;
            chk({"R6 ", exp_tag, " rvalid"}, {31'b0, io_rvalid}, {31'b0, exp_rvalid});
            if (exp_rvalid) chk({exp_tag, " rdata"}, io_rdata, exp_rdata);
            e_req = io_req && io_port >= 16'h0CFC && io_port <= 16'h0CFF && m_addr[31];
            chk("R3 R4 cfg_req", {31'b0, cfg_req}, {31'b0, e_req});
            if (e_req) begin
                chk("R3 cfg_bus", {24'b0, cfg_bus}, {24'b0, m_addr[23:16]});
                chk("R3 cfg_dev", {27'b0, cfg_dev}, {27'b0, m_addr[15:11]});
                chk("R3 cfg_fn",  {29'b0, cfg_fn},  {29'b0, m_addr[10:8]});
                chk("R3 cfg_dw",  {26'b0, cfg_dw},  {26'b0, m_addr[7:2]});
                chk("R3 cfg_we",  {31'b0, cfg_we},  {31'b0, io_we});
                chk("R5 cfg_be",  {28'b0, cfg_be},  {28'b0, io_be});
                if (io_we) chk("R3 cfg_wdata", cfg_wdata, io_wdata);
            end
        end
    end

    task automatic put(input logic we, input logic [15:0] port, input logic [3:0] be,
                       input logic [31:0] wd, input string tag);
        @(posedge clk); #3;
        io_req = 1'b1; io_we = we; io_port = port; io_be = be; io_wdata = wd; cur_tag = tag;
    endtask

    task automatic rd(input logic [15:0] port, input string tag);
        put(1'b0, port, 4'hF, 32'h0, tag);
    endtask

    task automatic wr(input logic [15:0] port, input logic [31:0] wd, input string tag);
        put(1'b1, port, 4'hF, wd, tag);
    endtask

    task automatic idle();
        @(posedge clk); #3;
        io_req = 1'b0; io_we = 1'b0; cur_tag = "R6";
    endtask

    initial begin
        #(200000 * 10);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 1'b0; io_req = 1'b0; io_we = 1'b0; io_port = 16'h0; io_be = 4'h0; io_wdata = 32'h0;
        repeat (3) @(posedge clk);
        #4;
        chk("R1 rvalid in reset", {31'b0, io_rvalid}, 32'h0);
        chk("R1 cfg_req in reset", {31'b0, cfg_req}, 32'h0);
        @(posedge clk); #3;
        rst_n = 1'b1; checking = 1'b1;

        rd(16'h0CF8, "R1");
        rd(16'h0CFC, "R4");
        wr(16'h0CFC, 32'hFFFF_FFFF, "R4");
        wr(16'h0CF8, 32'hFFFF_FFFF, "R2");
        rd(16'h0CF8, "R2");
        rd(16'h0CFC, "R7");
        put(1'b1, 16'h0CF9, 4'b0010, 32'h0, "R2");
        rd(16'h0CF8, "R2");
        wr(16'h0CF8, 32'h0000_1804, "R4");
        wr(16'h0CFC, 32'hFFFF_FFFF, "R4");
        rd(16'h0CFC, "R4");
        wr(16'h0CF8, 32'h8000_1800, "R3");
        rd(16'h0CFC, "R8");
        wr(16'h0CF8, 32'h8000_1808, "R8");
        rd(16'h0CFC, "R8");
        wr(16'h0CF8, 32'h8000_1804, "R11");
        rd(16'h0CFC, "R4 R11");
        wr(16'h0CFC, 32'hFFFF_FFFF, "R11");
        rd(16'h0CFC, "R11");
        wr(16'h0CF8, 32'h8000_180C, "R9");
        wr(16'h0CFC, 32'hFFFF_FFFF, "R9");
        rd(16'h0CFC, "R9");
        wr(16'h0CFC, 32'h0, "R9");
        put(1'b1, 16'h0CFD, 4'b0010, 32'hAB55_00CD, "R5");
        rd(16'h0CFC, "R5");
        wr(16'h0CF8, 32'h8000_1810, "R10");
        wr(16'h0CFC, 32'hFFFF_FFFF, "R10");
        rd(16'h0CFC, "R10");
        wr(16'h0CF8, 32'h8000_1814, "R10");
        wr(16'h0CFC, 32'hFFFF_FFFF, "R10");
        rd(16'h0CFC, "R10");
        wr(16'h0CF8, 32'h8000_183C, "R11");
        wr(16'h0CFC, 32'hFFFF_FFFF, "R11");
        rd(16'h0CFC, "R11");
        wr(16'h0CF8, 32'h8000_1840, "R11");
        wr(16'h0CFC, 32'hFFFF_FFFF, "R11");
        rd(16'h0CFC, "R11");
        wr(16'h0CF8, 32'h8000_2000, "R7");
        rd(16'h0CFC, "R7");
        wr(16'h0CF8, 32'h8000_1900, "R7");
        rd(16'h0CFC, "R7");
        wr(16'h0CF8, 32'h8001_1800, "R7");
        rd(16'h0CFC, "R7");
        wr(16'h0CF8, 32'h8000_1810, "R12");
        wr(16'h0080, 32'h0, "R12");
        wr(16'h0CF4, 32'h0, "R12");
        rd(16'h0080, "R12");
        rd(16'h0CF0, "R12");
        rd(16'h0CF8, "R12");
        rd(16'h0CFC, "R12");
        idle();
        idle();
        idle();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule